// File: doc/BRIEF.md
# Serial Audio Stereo Transmitter

This block turns stereo PCM samples into a one-bit serial audio stream, in either the I2S framing or the left-justified framing. A bit-clock tick input marks each serial bit period. The word-select signal comes from one of two places. In master mode a built-in divider generates it from the slot length, and the block drives it out. In slave mode it comes from an input pin. Samples reach the block through a single holding word with a ready/valid handshake. On each slot start the block loads the sample for that slot into a shift register and sends it MSB first, with zeros after the last data bit.

A 3-bit length code sets how wide the samples are. Two of the codes are packed forms, in which one holding word carries both channels of a frame. For 18-, 20- and 24-bit samples a slot-size bit chooses a 24-bit or a 32-bit slot. A mono switch repeats the left sample in the right slot. When a slot begins and no sample is waiting, the block sends a fill value and records the underrun. The fill value is either zero or the last sample sent on that channel. Transmission is turned on and off by one-cycle commands. A second output carries a copy of the serial data for an external receiver.

Top module: `serial_audio_tx`

## Requirements
- R1: The length code `cfg_len` gives the sample width: 0→32, 1→24, 2→20, 3→18, 4→16, 5→16 packed, 6→8, 7→8 packed. In the unpacked codes a sample is taken from the low bits of the holding word, `smp_data[n-1:0]`.
- R2: The slot length is 32 bits for code 0, 16 for codes 4 and 5, and 8 for codes 6 and 7. For codes 1 to 3 it is 24 when `cfg_slot24` is 1 and 32 when it is 0. Each slot carries its sample MSB first, followed by zeros to the end of the slot.
- R3: `cfg_fmt` = 1 selects left-justified framing: the MSB goes out on the first bit-clock tick of the slot. Every other value (0, 2, 3) selects I2S framing, in which the whole stream is delayed by one tick, so the MSB goes out on the second tick of the slot.
- R4: With `cfg_mono` = 1, one holding word is consumed per frame. The left sample taken from it is sent in both the left slot and the right slot.
- R5: With a packed code (5 or 7) and mono off, one holding word is consumed per frame. The left sample is in the low 16-bit half, at bits [n-1:0]. The right sample is in the high half, at bits [16+n-1:16].
- R6: A slot starts in underrun when no sample is waiting for it. In that case the slot carries zero if `cfg_fill_prev` = 0, and the last sample sent on that channel if `cfg_fill_prev` = 1. That last-sent value is reset to zero whenever transmission is off.
- R7: An underrun sets the sticky flag `st_underrun` and the bit of `st_ur_chan` for the channel concerned (bit 0 left, bit 1 right). Both stay set until a `cmd_tx_on` pulse clears them.
- R8: `cmd_tx_on` sets `st_enabled` and `cmd_tx_off` clears it; if both arrive in the same cycle, the off command wins. While transmission is off, `sd_out` and `ws_out` are held at 0 and ticks have no effect.
- R9: `smp_ready` is high whenever the holding word is empty. An accepted write drops it on the next cycle, and it rises again in the cycle after the word is moved into the shift register. A word written while transmission is off is kept.
- R10: In master mode (`cfg_master` = 1), `ws_out` starts low on enable, toggles once every slot-length ticks, and `ws_pin` is ignored. In slave mode, slots follow the changes of `ws_pin` sampled on ticks, and `ws_out` stays 0. The left slot is word-select low.
- R11: `sd_loop` always equals `sd_out`.
- R12: After reset, `smp_ready` = 1, and `st_enabled`, `st_underrun`, `st_ur_chan`, `sd_out` and `ws_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_tx_on | input | 1 | One-cycle enable command |
| cmd_tx_off | input | 1 | One-cycle disable command |
| cfg_master | input | 1 | 1: generate word select, 0: follow ws_pin |
| cfg_len | input | 3 | Sample length code |
| cfg_slot24 | input | 1 | 24-bit slot for 18/20/24-bit samples |
| cfg_fmt | input | 2 | Framing: 1 left-justified, others I2S |
| cfg_mono | input | 1 | Send left sample in both slots |
| cfg_fill_prev | input | 1 | Underrun fill: 1 last sample, 0 zero |
| bclk_tick | input | 1 | One-cycle pulse per serial bit period |
| ws_pin | input | 1 | External word select (slave mode) |
| smp_valid | input | 1 | Holding-word write request |
| smp_data | input | 32 | Holding-word write data |
| smp_ready | output | 1 | Holding word empty |
| sd_out | output | 1 | Serial data |
| sd_loop | output | 1 | Copy of serial data for a receiver |
| ws_out | output | 1 | Generated word select (master mode) |
| st_enabled | output | 1 | Transmission on |
| st_underrun | output | 1 | Sticky underrun summary |
| st_ur_chan | output | 2 | Sticky per-channel underrun flags |

## Verification
The main stream is run through every combination of length code, slot-size bit, all four framing codes, mono switch and fill mode. Each combination gets a short word supply that runs dry partway through three frames, and the serial output is compared bit by bit against a stream the bench computes from the requirements. Running the supply dry separates consumed samples from zero fill and from repeated fill. The packed and mono codes show whether the block takes one word or two per frame. The framing sweep tells the one-tick I2S delay apart from left-justified output. Directed cases add a slave run with a foreign slot length, underrun on the right channel only, commands issued together, ticks while disabled, and a word held across disable.

// File: rtl/sat_pkg.sv
// Shared constants and decode functions for the serial audio transmitter.
// Assumes a 32-bit holding word; packed codes split it into two halves.
package sat_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int LEN_W  = $clog2(WORD_W) + 1;

    // Sample width in bits for a length code.
    function automatic logic [LEN_W-1:0] sample_bits(input logic [2:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            3'd0:        n = LEN_W'(32);
            3'd1:        n = LEN_W'(24);
            3'd2:        n = LEN_W'(20);
            3'd3:        n = LEN_W'(18);
            3'd4, 3'd5:  n = LEN_W'(16);
            default:     n = LEN_W'(8);
        endcase
        return n;
    endfunction

    // Slot length in bit periods for a length code and slot-size bit.
    function automatic logic [LEN_W-1:0] slot_bits(input logic [2:0] code, input logic s24);
        logic [LEN_W-1:0] n;
        case (code)
            3'd0:              n = LEN_W'(32);
            3'd1, 3'd2, 3'd3:  n = s24 ? LEN_W'(24) : LEN_W'(32);
            3'd4, 3'd5:        n = LEN_W'(16);
            default:           n = LEN_W'(8);
        endcase
        return n;
    endfunction

    // Packed codes carry both channels of a frame in one word.
    function automatic logic is_packed(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd7);
    endfunction
endpackage

// File: rtl/sat_wsgen.sv
// Word-select generator for master mode.
// Counts bit-clock ticks and toggles ws after slot_len ticks.
// Assumes slot_len >= 2; held cleared (ws low) while en is low.
module sat_wsgen
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [LEN_W-1:0] slot_len,
    output logic             ws
);
    logic [LEN_W-1:0] cnt_q;

    // Slot-position counter and ws toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            ws    <= 1'b0;
        end else if (tick) begin
            if (cnt_q == slot_len - LEN_W'(1)) begin
                cnt_q <= '0;
                ws    <= ~ws;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    // R10
    ws_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(ws));
endmodule

// File: rtl/sat_hold.sv
// Holding word, pair store and slot sample selection.
// Chooses the sample for each slot: it comes from the holding word, from
// the stored partner of a packed or mono frame, or from the underrun fill.
// The sample is returned left-aligned in slot_word. Assumes slot_start
// occurs only while en is high.
module sat_hold
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        len_code,
    input  logic              mono,
    input  logic              fill_prev,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              slot_start,
    input  logic              slot_ch,
    output logic [WORD_W-1:0] slot_word,
    output logic              ur_pulse
);
    localparam logic [WORD_W:0] ONE_EXT = {{WORD_W{1'b0}}, 1'b1};

    logic [WORD_W-1:0] hold_q, pend_q, smp, mask, lo_smp, hi_smp, fill_val;
    logic [WORD_W-1:0] prev_q [2];
    logic [WORD_W:0]   mask_ext;
    logic [LEN_W-1:0]  nbits;
    logic              hold_full, pend_v, paired, needs_word, have, take;

    // Decode width, pick the slot sample and detect underrun.
    always_comb begin
        nbits      = sample_bits(len_code);
        paired     = mono || is_packed(len_code);
        needs_word = !slot_ch || !paired;
        mask_ext   = (ONE_EXT << nbits) - ONE_EXT;
        mask       = mask_ext[WORD_W-1:0];
        lo_smp     = hold_q & mask;
        hi_smp     = (hold_q >> HALF_W) & mask;
        fill_val   = fill_prev ? prev_q[slot_ch] : '0;
        have       = needs_word ? hold_full : pend_v;
        if (!have)
            smp = fill_val;
        else if (needs_word)
            smp = lo_smp;
        else
            smp = pend_q;
        take      = slot_start && needs_word && hold_full;
        ur_pulse  = slot_start && !have;
        slot_word = smp << (LEN_W'(WORD_W) - nbits);
        wr_ready  = !hold_full;
    end

    // Holding word: filled by a write, emptied when a slot takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_q    <= wr_data;
        end
    end

    // Partner sample for the right slot of a packed or mono frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pend_v <= 1'b0;
            pend_q <= '0;
        end else if (slot_start && !slot_ch) begin
            pend_v <= hold_full && paired;
            pend_q <= mono ? lo_smp : hi_smp;
        end else if (slot_start) begin
            pend_v <= 1'b0;
        end
    end

    // Last sample sent per channel, used as the repeat fill.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            prev_q[0] <= '0;
            prev_q[1] <= '0;
        end else if (slot_start) begin
            prev_q[slot_ch] <= smp;
        end
    end

    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);
endmodule

// File: rtl/sat_shift.sv
// Serial shifter with framing delay.
// Loads the slot word at slot start and shifts it out MSB first, one bit per
// tick. The I2S framing adds one tick of delay. Assumes slot_start only
// occurs together with tick.
module sat_shift
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              slot_start,
    input  logic [WORD_W-1:0] slot_word,
    input  logic              i2s_mode,
    output logic              sdo
);
    logic [WORD_W-1:0] sh_q;
    logic              bit_lj_q, bit_i2s_q;

    // Shift register, left-justified bit and one-tick-delayed bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh_q      <= '0;
            bit_lj_q  <= 1'b0;
            bit_i2s_q <= 1'b0;
        end else if (tick) begin
            bit_i2s_q <= bit_lj_q;
            if (slot_start) begin
                bit_lj_q <= slot_word[WORD_W-1];
                sh_q     <= slot_word << 1;
            end else begin
                bit_lj_q <= sh_q[WORD_W-1];
                sh_q     <= sh_q << 1;
            end
        end
    end

    assign sdo = i2s_mode ? bit_i2s_q : bit_lj_q;

    // R8
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sdo == 1'b0));
endmodule

// File: rtl/serial_audio_tx.sv
// Serial audio stereo transmitter top.
// Holds the enable state, selects the word-select source, finds slot starts
// and keeps the sticky underrun flags. Assumes bclk_tick is a one-cycle pulse
// that is never high in two consecutive cycles, and that ws_pin is
// synchronous to clk.
module serial_audio_tx
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_tx_on,
    input  logic              cmd_tx_off,
    input  logic              cfg_master,
    input  logic [2:0]        cfg_len,
    input  logic              cfg_slot24,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_mono,
    input  logic              cfg_fill_prev,
    input  logic              bclk_tick,
    input  logic              ws_pin,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    output logic              smp_ready,
    output logic              sd_out,
    output logic              sd_loop,
    output logic              ws_out,
    output logic              st_enabled,
    output logic              st_underrun,
    output logic [1:0]        st_ur_chan
);
    logic              en_q, ws_gen, ws_eff, ws_last_q, slot_start, ur;
    logic [WORD_W-1:0] slot_word;

    // Enable state from the command pulses; off wins.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_tx_off)
            en_q <= 1'b0;
        else if (cmd_tx_on)
            en_q <= 1'b1;
    end

    sat_wsgen u_wsgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q && cfg_master),
        .tick     (bclk_tick),
        .slot_len (slot_bits(cfg_len, cfg_slot24)),
        .ws       (ws_gen)
    );

    assign ws_eff     = cfg_master ? ws_gen : ws_pin;
    assign slot_start = en_q && bclk_tick && (ws_eff != ws_last_q);

    // Word select seen on the previous tick; preset high so the first tick finds a left slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q)
            ws_last_q <= 1'b1;
        else if (bclk_tick)
            ws_last_q <= ws_eff;
    end

    sat_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .len_code   (cfg_len),
        .mono       (cfg_mono),
        .fill_prev  (cfg_fill_prev),
        .wr_valid   (smp_valid),
        .wr_data    (smp_data),
        .wr_ready   (smp_ready),
        .slot_start (slot_start),
        .slot_ch    (ws_eff),
        .slot_word  (slot_word),
        .ur_pulse   (ur)
    );

    sat_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .tick       (bclk_tick),
        .slot_start (slot_start),
        .slot_word  (slot_word),
        .i2s_mode   (cfg_fmt != 2'd1),
        .sdo        (sd_out)
    );

    // Sticky underrun flags, cleared by the enable command.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_tx_on) begin
            st_underrun <= 1'b0;
            st_ur_chan  <= 2'b00;
        end else if (ur) begin
            st_underrun         <= 1'b1;
            st_ur_chan[ws_eff]  <= 1'b1;
        end
    end

    assign sd_loop    = sd_out;
    assign ws_out     = ws_gen;
    assign st_enabled = en_q;

    // R7
    ur_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_underrun && !cmd_tx_on) |=> st_underrun);
    // R7
    ur_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ur && !cmd_tx_on) |=> st_underrun);
    // R8
    off_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_tx_off |=> !st_enabled);
endmodule

// File: tb/serial_audio_tx_bench.sv
`timescale 1ns/1ps
// Bench: sweeps all configurations and compares the stream against a bench model.
module serial_audio_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_tx_on = 0, cmd_tx_off = 0, cfg_master = 1, cfg_slot24 = 0;
    logic [2:0]  cfg_len = 0;
    logic [1:0]  cfg_fmt = 0;
    logic        cfg_mono = 0, cfg_fill_prev = 0, bclk_tick = 0, ws_pin = 0;
    logic        smp_valid = 0;
    logic [31:0] smp_data = 0;
    logic        smp_ready, sd_out, sd_loop, ws_out, st_enabled, st_underrun;
    logic [1:0]  st_ur_chan;

    int vecs = 0, miss = 0;
    logic       exp_bit [0:255];
    logic [1:0] exp_ur;
    logic [31:0] wq [0:7];
    int widx = 0, wn = 0;

    always #5 clk = ~clk;

    serial_audio_tx u_serial_audio_tx (.*);

    function automatic int sbits(input int code);
        case (code)
            0: return 32; 1: return 24; 2: return 20; 3: return 18;
            4, 5: return 16; default: return 8;
        endcase
    endfunction

    function automatic int slen(input int code, input bit s24);
        if (code == 0) return 32;
        if (code <= 3) return s24 ? 24 : 32;
        if (code <= 5) return 16;
        return 8;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vecs++;
        if (act !== expv) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Writer: offer the next word whenever the holding word is empty.
    task automatic feed();
        if (widx < wn && smp_ready) begin
            smp_valid = 1'b1;
            smp_data  = wq[widx];
            widx++;
        end else begin
            smp_valid = 1'b0;
        end
    endtask

    // Expected left-justified stream for nf frames of slot length L.
    task automatic build(input int code, input bit mono, input bit fill,
                         input int nw, input int nf, input int L);
        int n, qi, t;
        bit packed_c, pv, needs;
        logic [31:0] pval, smp, w, mask, sw;
        logic [31:0] prev [2];
        n = sbits(code);
        packed_c = (code == 5) || (code == 7);
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        qi = 0; pv = 0; pval = 0; prev[0] = 0; prev[1] = 0; t = 0; exp_ur = 2'b00;
        for (int f = 0; f < nf; f++) begin
            for (int ch = 0; ch < 2; ch++) begin
                needs = (ch == 0) || (!mono && !packed_c);
                if (needs && qi < nw) begin
                    w = wq[qi]; qi++;
                    smp = w & mask;
                    if (ch == 0) begin
                        pval = mono ? smp : ((w >> 16) & mask);
                        pv = mono || packed_c;
                    end
                end else if (!needs && pv) begin
                    smp = pval; pv = 0;
                end else begin
                    smp = fill ? prev[ch] : 32'd0;
                    exp_ur[ch] = 1'b1;
                    pv = 0;
                end
                prev[ch] = smp;
                sw = smp << (32 - n);
                for (int k = 0; k < L; k++) begin
                    exp_bit[t] = sw[31-k];
                    t++;
                end
            end
        end
    endtask

    // One configuration: load words, enable, run nf frames and compare every tick.
    task automatic do_run(input int code, input bit s24, input int fmt, input bit mono,
                          input bit fill, input bit master, input int Lslave,
                          input int nw, input int nf, input int seed);
        int L, T;
        bit i2s;
        logic ebit, ews;
        @(negedge clk); cmd_tx_off = 1; smp_valid = 0;
        @(negedge clk); cmd_tx_off = 0;
        cfg_len = 3'(code); cfg_slot24 = s24; cfg_fmt = 2'(fmt); cfg_mono = mono;
        cfg_fill_prev = fill; cfg_master = master;
        wn = nw; widx = 0;
        for (int i = 0; i < nw; i++) wq[i] = (32'h9E37_79B9 * (seed * 8 + i + 1)) ^ 32'h5A5A_0F0F;
        repeat (3) begin @(negedge clk); feed(); end
        @(negedge clk); cmd_tx_on = 1; feed();
        @(negedge clk); cmd_tx_on = 0; feed();
        check("R7 flags cleared by enable", {30'd0, st_ur_chan}, 32'd0);
        check("R8 enabled after on command", {31'd0, st_enabled}, 32'd1);
        L = master ? slen(code, s24) : Lslave;
        T = 2 * nf * L;
        i2s = (fmt != 1);
        build(code, mono, fill, nw, nf, L);
        for (int t = 0; t < T; t++) begin
            @(negedge clk);
            bclk_tick = 1;
            ws_pin = master ? 1'(t & 1) : 1'((t / L) & 1);
            feed();
            @(negedge clk);
            bclk_tick = 0;
            feed();
            ebit = i2s ? ((t == 0) ? 1'b0 : exp_bit[t-1]) : exp_bit[t];
            check($sformatf("R1 R2 R3 R4 R5 R6 stream code=%0d s24=%0d fmt=%0d mono=%0d fill=%0d t=%0d",
                  code, s24, fmt, mono, fill, t), {31'd0, sd_out}, {31'd0, ebit});
            check("R11 loop copy", {31'd0, sd_loop}, {31'd0, sd_out});
            ews = master ? 1'(((t + 1) / L) & 1) : 1'b0;
            check($sformatf("R10 word select t=%0d", t), {31'd0, ws_out}, {31'd0, ews});
        end
        check("R7 per-channel underrun", {30'd0, st_ur_chan}, {30'd0, exp_ur});
        check("R7 underrun summary", {31'd0, st_underrun}, {31'd0, (exp_ur != 2'b00)});
    endtask

    initial begin
        #1_900_000;
        miss++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12
        check("R12 ready after reset", {31'd0, smp_ready}, 32'd1);
        check("R12 enabled after reset", {31'd0, st_enabled}, 32'd0);
        check("R12 flags after reset", {30'd0, st_ur_chan, st_underrun} , 32'd0);
        check("R12 outputs after reset", {30'd0, sd_out, ws_out}, 32'd0);

        // Full sweep, master mode, supply runs dry inside three frames.
        for (int code = 0; code < 8; code++)
            for (int s = 0; s < 2; s++)
                for (int fmt = 0; fmt < 4; fmt++)
                    for (int m = 0; m < 2; m++)
                        for (int fl = 0; fl < 2; fl++)
                            do_run(code, 1'(s), fmt, 1'(m), 1'(fl), 1'b1, 0, 2, 3,
                                   code * 32 + s * 16 + fmt * 4 + m * 2 + fl);

        // R7: only the right channel runs dry.
        do_run(4, 0, 1, 0, 1, 1'b1, 0, 5, 3, 300);
        check("R7 right-only underrun", {30'd0, st_ur_chan}, 32'd2);

        // R10: slave mode with a 28-tick slot from the pin, I2S framing, no underrun.
        do_run(1, 0, 0, 0, 0, 1'b0, 28, 6, 3, 301);
        check("R10 slave run has no underrun", {31'd0, st_underrun}, 32'd0);

        // R8: ticks while disabled leave the outputs at zero.
        @(negedge clk); cmd_tx_off = 1;
        @(negedge clk); cmd_tx_off = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); bclk_tick = 1;
            @(negedge clk); bclk_tick = 0;
            check("R8 quiet while off", {30'd0, sd_out, ws_out}, 32'd0);
        end
        // R8: on and off together leave it off.
        @(negedge clk); cmd_tx_on = 1; cmd_tx_off = 1;
        @(negedge clk); cmd_tx_on = 0; cmd_tx_off = 0;
        check("R8 off wins over on", {31'd0, st_enabled}, 32'd0);

        // R9: word kept across disabled time, released by the first slot.
        cfg_master = 1; cfg_len = 3'd4; cfg_fmt = 2'd1; cfg_mono = 0;
        check("R9 ready while empty", {31'd0, smp_ready}, 32'd1);
        @(negedge clk); smp_valid = 1; smp_data = 32'h0000_8001;
        @(negedge clk); smp_valid = 0;
        check("R9 ready low after write", {31'd0, smp_ready}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); bclk_tick = 1;
            @(negedge clk); bclk_tick = 0;
        end
        check("R9 word kept while off", {31'd0, smp_ready}, 32'd0);
        @(negedge clk); cmd_tx_on = 1;
        @(negedge clk); cmd_tx_on = 0; bclk_tick = 1;
        @(negedge clk); bclk_tick = 0;
        check("R9 ready after load", {31'd0, smp_ready}, 32'd1);
        check("R9 held word MSB sent", {31'd0, sd_out}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule